// File: doc/BRIEF.md
# Dual-Format Serial Audio Transmitter

This block turns a pair of parallel 20-bit audio samples (left and right) into one serial data line. The bit clock and the word-select clock come from outside. Both are oversampled by a fast system clock, and all state runs in that one clock domain. The word-select level picks the channel: low carries the left word and high carries the right word. A falling word-select edge starts a new frame, and at that moment both parallel inputs are captured together.

A static mode input chooses between two framings. In the I2S-style framing the first bit is delayed by one bit clock after the word-select change. In the left-justified framing the first bit appears on the first bit clock of the half. A second static input chooses which bit-clock edge the receiver samples on. The block always changes its output on the opposite edge. Words go out MSB first. Any bit slots beyond the twentieth in a half are filled with zeros.

Top module: `aud_ser_tx`

## Requirements
- R1: `sdout` is 0 while reset is asserted (reset acts asynchronously) and stays 0 until the first frame start, meaning the first launch edge at which `lrck` is seen low after being high.
- R2: With `fmt_lj`=0 (I2S-style, the default encoding) the MSB occupies bit slot 1 of each half. With `fmt_lj`=1 (left-justified) it occupies slot 0, the slot launched together with the `lrck` change.
- R3: The 20 bits of a word go out MSB first, one per bit slot, in consecutive slots.
- R4: Every slot in a half after the word's last bit carries 0.
- R5: With `cap_fall`=0 `sdout` changes only after falling `sclk` edges, so it is stable at each rising edge. With `cap_fall`=1 it changes only after rising edges, so it is stable at each falling edge.
- R6: Both `left_smp` and `right_smp` are captured at the frame start. Changes to them at any other time do not alter the words sent until the next frame start.
- R7: In I2S-style mode, when the previous half had exactly 20 slots, slot 0 of the new half carries that previous word's LSB.
- R8: Halves with `lrck`=0 carry the left word and halves with `lrck`=1 carry the right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | External bit clock |
| lrck | input | 1 | External word-select clock, changes on the launch edge of `sclk` |
| fmt_lj | input | 1 | 0: I2S-style framing, 1: left-justified framing |
| cap_fall | input | 1 | 0: receiver samples on rising `sclk`, 1: on falling `sclk` |
| left_smp | input | 20 | Parallel left sample |
| right_smp | input | 20 | Parallel right sample |
| sdout | output | 1 | Serial data out |

## Verification
A wrong slot counter or a wrong channel flag shows up as a shifted or swapped word in the very half where it occurs. This is because the counter restarts at every word-select change and each captured half is compared as a whole against the expected bit pattern. A fault in the capture registers shows up one half later, when the right word, or the left word of the next frame, fails to match samples that were deliberately changed in mid-frame. A fault in the carried-over LSB shows only in slot 0 of the half after a 20-slot half in I2S-style mode, so that case is driven for both channels and for both launch edges.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } aud_fmt_e;
endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              cap_fall_i,
  output logic              launch_o,
  output logic              new_half_o,
  output logic              frame_start_o,
  output logic              lr_o,
  output logic [SLOT_W-1:0] slot_n_o,
  output logic [SLOT_W-1:0] slot_q_o
);
  logic              sclk_d_q, sclk_d_n;
  logic              lr_q, lr_n;
  logic [SLOT_W-1:0] slot_q, slot_nxt, slot_adv;
  logic              rise, fall, launch, new_half;

  // edge detection and slot advance
  always_comb begin
    rise     = sclk_i & ~sclk_d_q;
    fall     = ~sclk_i & sclk_d_q;
    launch   = cap_fall_i ? rise : fall;
    new_half = launch & (lrck_i != lr_q);
    if (new_half)          slot_adv = '0;
    else if (slot_q == '1) slot_adv = slot_q;
    else                   slot_adv = slot_q + 1'b1;
  end

  // next state
  always_comb begin
    sclk_d_n = sclk_i;
    lr_n     = launch ? lrck_i : lr_q;
    slot_nxt = launch ? slot_adv : slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      lr_q     <= 1'b0;
      slot_q   <= '0;
    end else begin
      sclk_d_q <= sclk_d_n;
      lr_q     <= lr_n;
      slot_q   <= slot_nxt;
    end
  end

  assign launch_o      = launch;
  assign new_half_o    = new_half;
  assign frame_start_o = new_half & ~lrck_i;
  assign lr_o          = lrck_i;
  assign slot_n_o      = slot_adv;
  assign slot_q_o      = slot_q;
endmodule

// File: rtl/aud_tx_word.sv
module aud_tx_word #(
  parameter int WORD_W = 20,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_lj_i,
  input  logic              launch_i,
  input  logic              new_half_i,
  input  logic              frame_start_i,
  input  logic              lr_i,
  input  logic [SLOT_W-1:0] slot_n_i,
  input  logic [SLOT_W-1:0] slot_q_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              sdout_o
);
  import aud_tx_pkg::*;
  localparam int IDX_W = SLOT_W + 1;

  logic [WORD_W-1:0] l_hold_q, l_hold_n, r_hold_q, r_hold_n;
  logic              armed_q, armed_n, sdout_q, sdout_n;
  logic [WORD_W-1:0] word_cur, word_prev, shifted;
  logic [IDX_W-1:0]  lead, slot_ext, rel;
  logic              carry_case, bit_sel, grab;

  // bit selection
  always_comb begin
    grab       = launch_i & frame_start_i;
    word_cur   = frame_start_i ? left_i : (lr_i ? r_hold_q : l_hold_q);
    word_prev  = lr_i ? l_hold_q : r_hold_q;
    lead       = (aud_fmt_e'(fmt_lj_i) == FMT_LJ) ? '0 : IDX_W'(1);
    slot_ext   = {1'b0, slot_n_i};
    rel        = slot_ext - lead;
    shifted    = word_cur << rel;
    carry_case = new_half_i & (aud_fmt_e'(fmt_lj_i) == FMT_I2S)
               & (slot_q_i == SLOT_W'(WORD_W - 1));
    if (carry_case)
      bit_sel = word_prev[0];
    else if ((slot_ext >= lead) && (rel < IDX_W'(WORD_W)))
      bit_sel = shifted[WORD_W-1];
    else
      bit_sel = 1'b0;
  end

  // next state
  always_comb begin
    armed_n  = armed_q | grab;
    l_hold_n = grab ? left_i  : l_hold_q;
    r_hold_n = grab ? right_i : r_hold_q;
    sdout_n  = launch_i ? (armed_n & bit_sel) : sdout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_hold_q <= '0;
      r_hold_q <= '0;
      armed_q  <= 1'b0;
      sdout_q  <= 1'b0;
    end else begin
      l_hold_q <= l_hold_n;
      r_hold_q <= r_hold_n;
      armed_q  <= armed_n;
      sdout_q  <= sdout_n;
    end
  end

  assign sdout_o = sdout_q;

  p_quiet_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !sdout_q);

  p_hold_between_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_i |=> $stable(sdout_q));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_i && frame_start_i) |=> ($stable(l_hold_q) && $stable(r_hold_q)));

  p_lj_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && frame_start_i && fmt_lj_i) |=> (sdout_q == $past(left_i[WORD_W-1])));

  p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && !new_half_i && ({1'b0, slot_n_i} > IDX_W'(WORD_W))) |=> !sdout_q);
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int WORD_W      = 20,
  parameter int SLOT_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              lrck,
  input  logic              fmt_lj,
  input  logic              cap_fall,
  input  logic [WORD_W-1:0] left_smp,
  input  logic [WORD_W-1:0] right_smp,
  output logic              sdout
);
  logic       rst_sync_n;
  logic [1:0] clk_pair_s;
  logic       launch, new_half, frame_start, lr_now;
  logic [SLOT_W-1:0] slot_n, slot_q;

  aud_tx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (clk), .rst_n (rst_n), .d_i (1'b1), .q_o (rst_sync_n)
  );

  aud_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_clk_sync (
    .clk (clk), .rst_n (rst_sync_n), .d_i ({lrck, sclk}), .q_o (clk_pair_s)
  );

  aud_tx_framer #(.SLOT_W(SLOT_W)) u_framer (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .sclk_i        (clk_pair_s[0]),
    .lrck_i        (clk_pair_s[1]),
    .cap_fall_i    (cap_fall),
    .launch_o      (launch),
    .new_half_o    (new_half),
    .frame_start_o (frame_start),
    .lr_o          (lr_now),
    .slot_n_o      (slot_n),
    .slot_q_o      (slot_q)
  );

  aud_tx_word #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_word (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .fmt_lj_i      (fmt_lj),
    .launch_i      (launch),
    .new_half_i    (new_half),
    .frame_start_i (frame_start),
    .lr_i          (lr_now),
    .slot_n_i      (slot_n),
    .slot_q_i      (slot_q),
    .left_i        (left_smp),
    .right_i       (right_smp),
    .sdout_o       (sdout)
  );
endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sclk, lrck, fmt_lj, cap_fall, sdout;
  logic [19:0] left_smp, right_smp;

  aud_ser_tx u_dut (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .lrck (lrck),
    .fmt_lj (fmt_lj), .cap_fall (cap_fall),
    .left_smp (left_smp), .right_smp (right_smp), .sdout (sdout)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] cap;
  logic        mut_en;
  logic [19:0] mut_l, mut_r;

  // {lj, cap_fall, slots[7:0], A, B, C}
  localparam int NVEC = 7;
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'd24, 20'hA5C3E, 20'h3B71D, 20'h0F0F1},
    {1'b1, 1'b0, 8'd24, 20'h80001, 20'h7FFFE, 20'hC0FFE},
    {1'b0, 1'b0, 8'd20, 20'h9C3A5, 20'h4F0B2, 20'hE1D47},
    {1'b1, 1'b0, 8'd20, 20'h5A5A5, 20'hFFFFF, 20'h12345},
    {1'b0, 1'b1, 8'd32, 20'hDEAD1, 20'h0BEEF, 20'h55AA5},
    {1'b1, 1'b1, 8'd21, 20'h6C9F3, 20'hA0A0A, 20'h00001},
    {1'b0, 1'b1, 8'd20, 20'h12340, 20'hFEDCB, 20'h8F00D}
  };

  task automatic check_vec(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_half(input logic [19:0] w, input int n,
                                           input logic lj, input logic carry);
    logic [63:0] v;
    v = '0;
    for (int s = 0; s < n; s++) begin
      int idx;
      idx = lj ? s : s - 1;
      if (!lj && s == 0) v[s] = carry;
      else if (idx < 20) v[s] = w[19-idx];
    end
    return v;
  endfunction

  // one bit slot: launch edge (with lrck), sample, capture edge
  task automatic sclk_cycle(input logic lr, input int s);
    @(negedge clk);
    sclk = cap_fall;
    lrck = lr;
    if (mut_en && s == 10) begin
      left_smp  = mut_l;
      right_smp = mut_r;
    end
    repeat (8) @(negedge clk);
    cap[s] = sdout;
    sclk = ~cap_fall;
    repeat (7) @(negedge clk);
  endtask

  task automatic run_half(input logic lr, input int n);
    cap = '0;
    for (int s = 0; s < n; s++) sclk_cycle(lr, s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sclk  = ~cap_fall;
    lrck  = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; lrck = 1'b1; fmt_lj = 1'b0; cap_fall = 1'b0;
    left_smp = '0; right_smp = '0; mut_en = 1'b0; mut_l = '0; mut_r = '0;
    repeat (3) @(negedge clk);
    check_vec("R1 reset", {63'd0, sdout}, 64'd0);

    for (int e = 0; e < NVEC; e++) begin
      logic lj; logic cf; int n; logic [19:0] a, b, c; logic i2s20;
      {lj, cf} = VEC[e][69:68];
      n = int'(VEC[e][67:60]);
      a = VEC[e][59:40]; b = VEC[e][39:20]; c = VEC[e][19:0];
      i2s20 = !lj && n == 20;
      fmt_lj = lj; cap_fall = cf;
      left_smp = a; right_smp = b;
      do_reset();
      mut_en = 1'b0;
      run_half(1'b1, n);
      check_vec("R1 unarmed half", cap, 64'd0);
      mut_en = 1'b1; mut_l = ~a; mut_r = ~b;
      run_half(1'b0, n);
      check_vec("R2 R3 R4 R5 R8 left", cap, exp_half(a, n, lj, 1'b0));
      mut_en = 1'b0;
      run_half(1'b1, n);
      check_vec("R6 R7 R8 right", cap, exp_half(b, n, lj, i2s20 ? a[0] : 1'b0));
      left_smp = c;
      run_half(1'b0, n);
      check_vec("R6 R7 next left", cap, exp_half(c, n, lj, i2s20 ? b[0] : 1'b0));
    end

    // reset in mid-word
    fmt_lj = 1'b1; cap_fall = 1'b0;
    left_smp = 20'hFFFFF; right_smp = '0;
    do_reset();
    run_half(1'b1, 4);
    cap = '0;
    for (int s = 0; s < 3; s++) sclk_cycle(1'b0, s);
    check_vec("R2 mid-word level", {63'd0, sdout}, 64'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_vec("R1 async reset", {63'd0, sdout}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule